// File: doc/BRIEF.md
# SHA-3 Message Padder and Block Feeder

This block sits between a byte stream and a Keccak sponge core. Message bytes arrive one per accepted beat. The block packs them into 32-bit words and applies the SHA-3 padding. It then writes each rate-sized block into the core's 50-word state window and starts the core with the correct strobe. The first block of a message uses one strobe, which loads the rate and clears the capacity. Every later block uses the other strobe, which XORs the rate into the state.

A 2-bit variant input selects SHA3-224, -256, -384 or -512, and that choice sets the rate. The variant is captured on the first beat of a message and held until the message is finished.

The byte input is valid/ready. A beat transfers on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` is a registered-state function that never depends on `in_valid`. It is low while a block is being padded, written or zero-filled, while a start strobe is pending, and whenever `core_ready` is low. A source may hold `in_valid` high with stable data for as long as it likes.

Top module: `sha3_msg_padder`

## Requirements
- R1: Variant code 0, 1, 2 and 3 select a rate of 144, 136, 104 and 72 bytes respectively, which is 36, 34, 26 and 18 words.
- R2: The earliest byte of each group of four lands in bits 31:24 of the word. Rate byte offset k goes to word address k/4 of the block. For example, "abc" produces word 0 = 0x61626306.
- R3: The byte 0x06 follows the last message byte and zeros follow it. The last rate word carries 0x80 in bits 7:0. When both fall on the same byte, that byte is 0x86.
- R4: A message whose length is a multiple of the rate gets an extra block that holds only padding. An empty message, sent as one beat with `in_nobyte` set, yields a single padding block.
- R5: For the first block, all 50 words (addresses 0..49) are written, with zeros at and above the rate, and then `first_go` pulses. For each later block, exactly the rate words are written, and then `next_go` pulses. The two strobes are never high together.
- R6: Each start strobe is high for one cycle. No word write happens in a strobe cycle, and the last write of the block comes before the strobe.
- R7: After a strobe, no word write and no accepted beat occur until `core_ready` has been seen high in a later cycle.
- R8: `in_ready` is high only when `core_ready` is high and the block is collecting message bytes.
- R9: The variant is sampled on the first beat of a message. A change on `mode_i` later in the same message has no effect on the rate used.
- R10: `msg_done` is a one-cycle pulse, given exactly once per message, after the core is ready following the final block.
- R11: After reset, nothing is written, no strobe or done pulse is raised, and `in_ready` follows `core_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Variant select (0=224, 1=256, 2=384, 3=512) |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Byte beat accepted when high with valid |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Beat carries the final byte |
| in_nobyte | input | 1 | Beat carries no byte and ends an empty message |
| core_ready | input | 1 | Core idle and able to take a block |
| wr_en | output | 1 | State word write strobe |
| wr_addr | output | 6 | State word address 0..49 |
| wr_data | output | 32 | State word data |
| first_go | output | 1 | Start absorb of the first block (load and clear) |
| next_go | output | 1 | Start absorb of a later block (XOR rate) |
| msg_done | output | 1 | Final block of the message absorbed |

## Verification
A wrong byte position or a wrong padding flag appears in the word written for that position, in the same block. The per-block word comparison catches it before the strobe. A wrong rate or block-end decision shows up as a wrong write count, a misplaced 0x80, or a wrong number of strobes per message. These errors are visible by the end of the affected block. A stale first-block flag or a lost padding-pending flag changes the strobe kind or drops the extra padding block, and this is seen at the next strobe or at `msg_done`. A latched variant that follows `mode_i` mid-message changes the length of the second block.

// File: rtl/sha3pad_pkg.sv
`timescale 1ns/1ps
package sha3pad_pkg;
  localparam int STATE_BITS  = 1600;
  localparam int WORD_BITS   = 32;
  localparam int STATE_WORDS = STATE_BITS / WORD_BITS;
  localparam int ADDR_W      = $clog2(STATE_WORDS);
  localparam int POS_W       = 8;
  localparam logic [7:0] PAD_HEAD = 8'h06;
  localparam logic [7:0] PAD_TAIL = 8'h80;

  typedef enum logic [1:0] {V224 = 2'd0, V256 = 2'd1, V384 = 2'd2, V512 = 2'd3} variant_e;

  typedef enum logic [2:0] {
    ST_LOAD, ST_PAD, ST_ZERO, ST_DRAIN, ST_WAIT
  } ctrl_st_e;

  // rate in bytes = (state - 2*digest) / 8
  function automatic logic [POS_W-1:0] rate_bytes(variant_e v);
    logic [11:0] cap_bits;
    case (v)
      V224:    cap_bits = 12'd448;
      V256:    cap_bits = 12'd512;
      V384:    cap_bits = 12'd768;
      default: cap_bits = 12'd1024;
    endcase
    return POS_W'((12'(STATE_BITS) - cap_bits) >> 3);
  endfunction
endpackage

// File: rtl/sha3pad_rate.sv
`timescale 1ns/1ps
module sha3pad_rate
  import sha3pad_pkg::*;
(
  input  variant_e                variant,
  output logic [POS_W-1:0]        rate_b,
  output logic [ADDR_W-1:0]       rate_w
);
  localparam int LANE_SH = $clog2(WORD_BITS / 8);
  logic [POS_W-1:0] rb;
  always_comb begin
    rb     = rate_bytes(variant);
    rate_b = rb;
    rate_w = ADDR_W'(rb >> LANE_SH);
  end
endmodule

// File: rtl/sha3pad_packer.sv
`timescale 1ns/1ps
module sha3pad_packer
  import sha3pad_pkg::*;
#(
  parameter int W_BITS = WORD_BITS,
  parameter int P_W    = POS_W,
  parameter int A_W    = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             put,
  input  logic [7:0]       put_byte,
  input  logic [P_W-1:0]   put_pos,
  input  logic             zero_put,
  input  logic [A_W-1:0]   zero_addr,
  output logic             wr_en,
  output logic [A_W-1:0]   wr_addr,
  output logic [W_BITS-1:0] wr_data
);
  localparam int LANES  = W_BITS / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int ACC_W  = W_BITS - 8;

  logic [ACC_W-1:0] acc;
  logic             word_full;

  assign word_full = (put_pos[LANE_W-1:0] == {LANE_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (put) begin
        acc <= {acc[ACC_W-9:0], put_byte};
        if (word_full) begin
          wr_en   <= 1'b1;
          wr_addr <= A_W'(put_pos >> LANE_W);
          wr_data <= {acc, put_byte};
        end
      end else if (zero_put) begin
        wr_en   <= 1'b1;
        wr_addr <= zero_addr;
        wr_data <= '0;
      end
    end
  end
endmodule

// File: rtl/sha3pad_ctrl.sv
`timescale 1ns/1ps
module sha3pad_ctrl
  import sha3pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_nobyte,
  input  logic              core_ready,
  output logic              first_go,
  output logic              next_go,
  output logic              msg_done,
  output variant_e          var_eff,
  input  logic [POS_W-1:0]  rate_b,
  input  logic [ADDR_W-1:0] rate_w,
  output logic              put,
  output logic [7:0]        put_byte,
  output logic [POS_W-1:0]  put_pos,
  output logic              zero_put,
  output logic [ADDR_W-1:0] zero_addr
);
  ctrl_st_e           state;
  logic [POS_W-1:0]   bpos;
  logic [ADDR_W-1:0]  zidx;
  logic               first_blk, head_due, final_blk, msg_act;
  logic               go_q, go_first_q, done_q;
  variant_e           mode_q;
  logic               accept, blk_end;

  assign var_eff  = msg_act ? mode_q : variant_e'(mode_i);
  assign in_ready = (state == ST_LOAD) && core_ready;
  assign accept   = in_valid && in_ready;
  assign blk_end  = (bpos == rate_b - POS_W'(1));

  always_comb begin
    put       = (accept && !in_nobyte) || (state == ST_PAD);
    put_byte  = in_data;
    if (state == ST_PAD)
      put_byte = (head_due ? PAD_HEAD : 8'h00) | (blk_end ? PAD_TAIL : 8'h00);
    put_pos   = bpos;
    zero_put  = (state == ST_ZERO);
    zero_addr = zidx;
  end

  assign first_go = go_q && go_first_q;
  assign next_go  = go_q && !go_first_q;
  assign msg_done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_LOAD;
      bpos       <= '0;
      zidx       <= '0;
      first_blk  <= 1'b1;
      head_due   <= 1'b0;
      final_blk  <= 1'b0;
      msg_act    <= 1'b0;
      mode_q     <= V224;
      go_q       <= 1'b0;
      go_first_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (state)
        ST_LOAD: if (accept) begin
          if (!msg_act) begin
            msg_act <= 1'b1;
            mode_q  <= variant_e'(mode_i);
          end
          if (in_nobyte) begin
            head_due <= 1'b1;
            state    <= ST_PAD;
          end else begin
            if (in_last) head_due <= 1'b1;
            if (blk_end) begin
              bpos  <= '0;
              zidx  <= rate_w;
              state <= first_blk ? ST_ZERO : ST_DRAIN;
            end else begin
              bpos <= bpos + POS_W'(1);
              if (in_last) state <= ST_PAD;
            end
          end
        end
        ST_PAD: begin
          head_due <= 1'b0;
          if (blk_end) begin
            final_blk <= 1'b1;
            bpos      <= '0;
            zidx      <= rate_w;
            state     <= first_blk ? ST_ZERO : ST_DRAIN;
          end else begin
            bpos <= bpos + POS_W'(1);
          end
        end
        ST_ZERO: begin
          if (zidx == ADDR_W'(STATE_WORDS - 1)) state <= ST_DRAIN;
          else zidx <= zidx + ADDR_W'(1);
        end
        ST_DRAIN: begin
          go_q       <= 1'b1;
          go_first_q <= first_blk;
          first_blk  <= 1'b0;
          state      <= ST_WAIT;
        end
        ST_WAIT: if (!go_q && core_ready) begin
          if (final_blk) begin
            done_q    <= 1'b1;
            final_blk <= 1'b0;
            msg_act   <= 1'b0;
            first_blk <= 1'b1;
            state     <= ST_LOAD;
          end else begin
            state <= head_due ? ST_PAD : ST_LOAD;
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/sha3_msg_padder.sv
`timescale 1ns/1ps
module sha3_msg_padder
  import sha3pad_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_i,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_nobyte,
  input  logic        core_ready,
  output logic        wr_en,
  output logic [5:0]  wr_addr,
  output logic [31:0] wr_data,
  output logic        first_go,
  output logic        next_go,
  output logic        msg_done
);
  variant_e           var_eff;
  logic [POS_W-1:0]   rate_b;
  logic [ADDR_W-1:0]  rate_w;
  logic               put, zero_put;
  logic [7:0]         put_byte;
  logic [POS_W-1:0]   put_pos;
  logic [ADDR_W-1:0]  zero_addr;

  sha3pad_rate u_rate (.variant(var_eff), .rate_b(rate_b), .rate_w(rate_w));

  sha3pad_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_nobyte(in_nobyte), .core_ready(core_ready),
    .first_go(first_go), .next_go(next_go), .msg_done(msg_done),
    .var_eff(var_eff), .rate_b(rate_b), .rate_w(rate_w),
    .put(put), .put_byte(put_byte), .put_pos(put_pos),
    .zero_put(zero_put), .zero_addr(zero_addr)
  );

  sha3pad_packer u_pack (
    .clk(clk), .rst_n(rst_n), .put(put), .put_byte(put_byte),
    .put_pos(put_pos), .zero_put(zero_put), .zero_addr(zero_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/sha3_msg_padder_chk.sv
`timescale 1ns/1ps
module sha3_msg_padder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       core_ready,
  input logic       wr_en,
  input logic [5:0] wr_addr,
  input logic       first_go,
  input logic       next_go,
  input logic       msg_done
);
  a_r8_ready_needs_core: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> core_ready);
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(first_go && next_go));
  a_r5_addr_in_state: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < 6'd50));
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (first_go || next_go) |=> !(first_go || next_go));
  a_r6_no_write_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (first_go || next_go) |-> !wr_en);
  a_r7_no_accept_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (first_go || next_go) |-> !(in_valid && in_ready));
  a_r7_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (first_go || next_go) |=> !wr_en && !in_ready);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> !msg_done);
endmodule

bind sha3_msg_padder sha3_msg_padder_chk u_chk (.*);

// File: tb/sha3_msg_padder_tb.sv
`timescale 1ns/1ps
module sha3_msg_padder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic in_valid = 1'b0, in_last = 1'b0, in_nobyte = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, wr_en, first_go, next_go, msg_done, core_ready;
  logic [5:0] wr_addr;
  logic [31:0] wr_data;
  logic crdy, hold = 1'b0;
  int ccnt;

  always #2.5 clk = ~clk;
  assign core_ready = crdy && !hold;

  sha3_msg_padder u_dut (.*);

  // simple core model: busy for a few cycles after any strobe
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin crdy <= 1'b1; ccnt <= 0; end
    else if (first_go || next_go) begin crdy <= 1'b0; ccnt <= 5; end
    else if (ccnt != 0) begin ccnt <= ccnt - 1; if (ccnt == 1) crdy <= 1'b1; end

  int tests = 0, fails = 0;
  logic [7:0]  mbuf [512];
  logic [31:0] cur [50];
  logic [31:0] cap [4][50];
  int cap_kind [4], cap_wr [4];
  int nblk = 0, wrcnt = 0, done_cnt = 0, viol = 0;
  bit pend = 0;

  always @(posedge clk) if (rst_n) begin
    if (pend && (wr_en || (in_valid && in_ready))) viol++;
    if (first_go || next_go) pend = 1;
    else if (pend && core_ready) pend = 0;
    if (wr_en) begin cur[wr_addr] = wr_data; wrcnt++; end
    if (first_go || next_go) begin
      if (nblk < 4) begin
        for (int w = 0; w < 50; w++) cap[nblk][w] = cur[w];
        cap_kind[nblk] = first_go ? 1 : 2;
        cap_wr[nblk] = wrcnt;
      end
      nblk++; wrcnt = 0;
    end
    if (msg_done) done_cnt++;
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int rate_b(int md);
    case (md) 0: return 144; 1: return 136; 2: return 104; default: return 72; endcase
  endfunction

  function automatic logic [7:0] exp_byte(int i, int len, int nb, int rb);
    logic [7:0] v;
    if (i < len) return mbuf[i];
    v = 8'h00;
    if (i == len) v |= 8'h06;
    if (i == nb * rb - 1) v |= 8'h80;
    return v;
  endfunction

  function automatic logic [31:0] exp_word(int b, int w, int len, int md);
    int rb = rate_b(md);
    int nb = len / rb + 1;
    logic [31:0] r = '0;
    if (w >= rb / 4) return 32'h0;
    for (int k = 0; k < 4; k++) r = {r[23:0], exp_byte(b * rb + w * 4 + k, len, nb, rb)};
    return r;
  endfunction

  task automatic beat(logic [7:0] d, logic last, logic nob);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last; in_nobyte = nob;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_nobyte = 1'b0;
  endtask

  task automatic run_msg(int len, int md, int chg_at, int chg_md);
    nblk = 0; wrcnt = 0; done_cnt = 0;
    mode_i = 2'(md);
    if (len == 0) beat(8'h00, 1'b1, 1'b1);
    for (int i = 0; i < len; i++) begin
      beat(mbuf[i], i == len - 1, 1'b0);
      if (i == chg_at) mode_i = 2'(chg_md);
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(done_cnt == 1, "R10", "done pulses", 32'(done_cnt), 1);
    chk(viol == 0, "R7", "activity while core busy", 32'(viol), 0);
  endtask

  task automatic verify(int len, int md);
    int rb = rate_b(md);
    int rw = rb / 4;
    int nb = len / rb + 1;
    chk(nblk == nb, "R4", "block count", 32'(nblk), 32'(nb));
    for (int b = 0; b < nb && b < 4; b++) begin
      int lim = (b == 0) ? 50 : rw;
      int bad = -1;
      logic [31:0] ba = '0, be = '0;
      chk(cap_kind[b] == ((b == 0) ? 1 : 2), "R5", "strobe kind", 32'(cap_kind[b]), (b == 0) ? 1 : 2);
      chk(cap_wr[b] == lim, "R1/R5", "words written", 32'(cap_wr[b]), 32'(lim));
      for (int w = 0; w < lim; w++) begin
        logic [31:0] e = exp_word(b, w, len, md);
        if (cap[b][w] !== e && bad < 0) begin bad = w; ba = cap[b][w]; be = e; end
      end
      chk(bad < 0, "R3", $sformatf("block %0d word %0d", b, bad), ba, be);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R11", "in_ready after reset", 32'(in_ready), 1);
    chk(wr_en == 1'b0, "R11", "wr_en after reset", 32'(wr_en), 0);
    chk(!first_go && !next_go, "R11", "strobes after reset", 32'({first_go, next_go}), 0);
    chk(msg_done == 1'b0, "R11", "done after reset", 32'(msg_done), 0);
  endtask

  task automatic t_hold();
    @(negedge clk); hold = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R8", "in_ready with core busy", 32'(in_ready), 0);
    hold = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8", "in_ready with core free", 32'(in_ready), 1);
  endtask

  task automatic t_abc();
    mbuf[0] = 8'h61; mbuf[1] = 8'h62; mbuf[2] = 8'h63;
    run_msg(3, 1, -1, 0);
    verify(3, 1);
    chk(cap[0][0] == 32'h61626306, "R2", "abc first word", cap[0][0], 32'h61626306);
    chk(cap[0][33] == 32'h00000080, "R1", "256 tail word", cap[0][33], 32'h80);
  endtask

  task automatic t_empty(int md);
    int rw = rate_b(md) / 4;
    run_msg(0, md, -1, 0);
    verify(0, md);
    chk(cap[0][0] == 32'h06000000, "R4", "empty head word", cap[0][0], 32'h06000000);
    chk(cap[0][rw - 1] == 32'h00000080, "R1", "empty tail word", cap[0][rw - 1], 32'h80);
  endtask

  task automatic fill(int len, int seed);
    for (int i = 0; i < len; i++) mbuf[i] = 8'(i * 37 + seed);
  endtask

  task automatic t_pad86();
    fill(71, 5);
    run_msg(71, 3, -1, 0);
    verify(71, 3);
    chk(cap[0][17][7:0] == 8'h86, "R3", "merged pad byte", 32'(cap[0][17][7:0]), 32'h86);
  endtask

  task automatic t_exact();
    fill(72, 11);
    run_msg(72, 3, -1, 0);
    verify(72, 3);
    chk(cap[1][0] == 32'h06000000 && cap[1][17] == 32'h80, "R4", "pad-only block", cap[1][0], 32'h06000000);
  endtask

  task automatic t_multi();
    fill(200, 3);
    run_msg(200, 2, -1, 0);
    verify(200, 2);
  endtask

  task automatic t_modechg();
    fill(150, 9);
    run_msg(150, 0, 10, 3);
    verify(150, 0);
    chk(cap_wr[1] == 36, "R9", "later block length after mode change", 32'(cap_wr[1]), 36);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hold();
    t_abc();
    t_empty(0);
    t_empty(3);
    t_pad86();
    t_exact();
    t_multi();
    t_modechg();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule